// File: doc/BRIEF.md
# Multi-Mode Effective Address Generator

This unit turns the operand fields of a 32-bit fixed-width instruction into the address the core will use, for any of seven addressing modes. A mode code selects how the address is formed: from an absolute address carried with the instruction, from a register alone, from the sum of two registers, from a register plus a sign-extended 16-bit displacement, relative to the program counter for branches, by splicing a 26-bit jump field under the upper PC bits, or by fetching the final address from memory at the location a register points to.

Six of the modes are pure arithmetic. They answer in the cycle the request is presented, and the unit stays ready for the next request. The memory-indirect mode instead issues one read on a simple memory port, holds a busy flag while it waits for the data, and presents the fetched word as the address one cycle after the read data arrives. A mode code outside the defined set gives a zero address and raises an illegal-mode flag.

Top module: `eff_addr_gen`

## Requirements
- R1: Mode 3'd0 (absolute): with `req` high and the unit not busy, `ea` equals `abs_addr` and `ea_valid` is high in that same cycle.
- R2: Mode 3'd1 (register): `ea` equals `ra` unchanged.
- R3: Mode 3'd2 (register pair): `ea` equals `ra + rb` modulo 2^32.
- R4: Mode 3'd3 (base plus displacement): `ea` equals `ra` plus `imm` sign-extended from bit 15 to 32 bits, modulo 2^32.
- R5: Mode 3'd4 (PC-relative): `ea` equals `pc + 4` plus `imm` sign-extended and shifted left by 2, modulo 2^32.
- R6: Mode 3'd5 (jump): `ea` equals bits 31..28 of `pc + 4`, then `jfield` in bits 27..2, then bits 1..0 zero.
- R7: Modes 3'd0 to 3'd5 never assert `mem_rd_en` or `busy`; `ea_valid` is high only in the request cycle, and `ea` is zero while `ea_valid` is low.
- R8: Mode 3'd6 (indirect): in the request cycle `mem_rd_en` is high for one cycle with `mem_rd_addr` equal to `ra` and `ea_valid` low; `busy` is high from the next cycle through the result cycle; `ea_valid` is high with `ea` equal to `mem_rd_data` in the cycle after the one in which `mem_rd_valid` is high, and `busy` falls the cycle after that.
- R9: While `busy` is high, `req` is ignored (no `ea_valid` other than the indirect result, no `mem_rd_en`, no `illegal`), and `mem_rd_valid` outside an outstanding read is ignored.
- R10: Mode 3'd7: `ea` is zero, `ea_valid` is low and `illegal` is high in the request cycle.
- R11: While `rst` is high and the cycle after it, `busy`, `ea_valid` and `mem_rd_en` are low (with `req` low), and a reset during an outstanding read returns the unit to ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | Address request for the current fields |
| mode | input | 3 | Addressing mode code |
| pc | input | 32 | Address of the current instruction |
| ra | input | 32 | First register value (base / pointer) |
| rb | input | 32 | Second register value |
| imm | input | 16 | Displacement or word-count branch offset |
| jfield | input | 26 | Jump address field |
| abs_addr | input | 32 | Absolute address carried with the instruction |
| mem_rd_en | output | 1 | Memory read request (indirect mode) |
| mem_rd_addr | output | 32 | Memory read address |
| mem_rd_valid | input | 1 | Memory read data is present |
| mem_rd_data | input | 32 | Memory read data |
| ea | output | 32 | Effective address |
| ea_valid | output | 1 | `ea` holds a result this cycle |
| busy | output | 1 | An indirect fetch is in progress |
| illegal | output | 1 | Undefined mode requested |

## Verification
The cycle in which an indirect fetch delivers its result is also a cycle in which a new request can be standing on the inputs, so the two paths compete for `ea` and `ea_valid`. The bench holds `req` high through the whole indirect fetch with arithmetic and undefined mode codes and chosen register values, and at the result cycle requires `ea` to be exactly the fetched word rather than the arithmetic address, with no read, no illegal flag and no extra valid pulse in any of the busy cycles. The arithmetic modes are swept with corner and pseudo-random operands, and the indirect path with read latencies of zero to several cycles.

// File: rtl/ea_pkg.sv
package ea_pkg;

    localparam int XLEN       = 32;
    localparam int IMM_W      = 16;
    localparam int JMP_W      = 26;
    localparam int MODE_W     = 3;
    localparam int INSN_BYTES = 4;
    localparam int WORD_SHIFT = 2;
    localparam int JMP_HI_W   = XLEN - JMP_W - WORD_SHIFT;

    typedef enum logic [MODE_W-1:0] {
        MODE_ABS      = 3'd0,
        MODE_REG      = 3'd1,
        MODE_REG_PAIR = 3'd2,
        MODE_BASE_OFS = 3'd3,
        MODE_PC_REL   = 3'd4,
        MODE_JUMP     = 3'd5,
        MODE_INDIRECT = 3'd6,
        MODE_UNUSED   = 3'd7
    } ea_mode_e;

    typedef enum logic [1:0] {
        IND_IDLE = 2'd0,
        IND_WAIT = 2'd1,
        IND_DONE = 2'd2
    } ind_state_e;

    typedef struct packed {
        logic [XLEN-1:0] addr;
        logic            arith_ok;
        logic            needs_mem;
        logic            bad_mode;
    } ea_calc_t;

    function automatic logic [XLEN-1:0] sext_imm(input logic [IMM_W-1:0] v);
        return {{(XLEN-IMM_W){v[IMM_W-1]}}, v};
    endfunction

    function automatic logic [XLEN-1:0] next_pc(input logic [XLEN-1:0] p);
        return p + XLEN'(INSN_BYTES);
    endfunction

    function automatic logic [XLEN-1:0] branch_target(input logic [XLEN-1:0] p,
                                                      input logic [IMM_W-1:0] ofs);
        return next_pc(p) + (sext_imm(ofs) << WORD_SHIFT);
    endfunction

    function automatic logic [XLEN-1:0] jump_target(input logic [XLEN-1:0] p,
                                                    input logic [JMP_W-1:0] jf);
        logic [XLEN-1:0] hi_mask;
        hi_mask = {{JMP_HI_W{1'b1}}, {(XLEN-JMP_HI_W){1'b0}}};
        return (next_pc(p) & hi_mask) | (XLEN'(jf) << WORD_SHIFT);
    endfunction

endpackage

// File: rtl/ea_mode_calc.sv
module ea_mode_calc
    import ea_pkg::*;
(
    input  logic [MODE_W-1:0] mode,
    input  logic [XLEN-1:0]   pc,
    input  logic [XLEN-1:0]   ra,
    input  logic [XLEN-1:0]   rb,
    input  logic [IMM_W-1:0]  imm,
    input  logic [JMP_W-1:0]  jfield,
    input  logic [XLEN-1:0]   abs_addr,
    output ea_calc_t          res
);

    always_comb begin
        res = '0;
        unique case (ea_mode_e'(mode))
            MODE_ABS: begin
                res.addr     = abs_addr;
                res.arith_ok = 1'b1;
            end
            MODE_REG: begin
                res.addr     = ra;
                res.arith_ok = 1'b1;
            end
            MODE_REG_PAIR: begin
                res.addr     = ra + rb;
                res.arith_ok = 1'b1;
            end
            MODE_BASE_OFS: begin
                res.addr     = ra + sext_imm(imm);
                res.arith_ok = 1'b1;
            end
            MODE_PC_REL: begin
                res.addr     = branch_target(pc, imm);
                res.arith_ok = 1'b1;
            end
            MODE_JUMP: begin
                res.addr     = jump_target(pc, jfield);
                res.arith_ok = 1'b1;
            end
            MODE_INDIRECT: begin
                res.addr      = ra;
                res.needs_mem = 1'b1;
            end
            default: begin
                res.bad_mode = 1'b1;
            end
        endcase
    end

endmodule

// File: rtl/ea_ind_fsm.sv
module ea_ind_fsm
    import ea_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            start,
    input  logic            rd_valid,
    input  logic [XLEN-1:0] rd_data,
    output logic            busy,
    output logic            done,
    output logic [XLEN-1:0] word
);

    ind_state_e      state_q, state_d;
    logic [XLEN-1:0] word_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            IND_IDLE: if (start)    state_d = IND_WAIT;
            IND_WAIT: if (rd_valid) state_d = IND_DONE;
            IND_DONE:               state_d = IND_IDLE;
            default:                state_d = IND_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= IND_IDLE;
            word_q  <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == IND_WAIT && rd_valid) word_q <= rd_data;
        end
    end

    assign busy = (state_q != IND_IDLE);
    assign done = (state_q == IND_DONE);
    assign word = word_q;

    // R8: returned data leads to the result one cycle later
    assert_result_follows_data_R8: assert property (@(posedge clk) disable iff (rst)
        (busy && !done && rd_valid) |=> (done && word == $past(rd_data)));

    // R8: a started fetch makes the unit busy on the next cycle
    assert_start_sets_busy_R8: assert property (@(posedge clk) disable iff (rst)
        (start && !busy) |=> busy);

    // R8: busy ends right after the result cycle
    assert_busy_ends_R8: assert property (@(posedge clk) disable iff (rst)
        done |=> !busy);

endmodule

// File: rtl/eff_addr_gen.sv
module eff_addr_gen
    import ea_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                req,
    input  logic [MODE_W-1:0]   mode,
    input  logic [XLEN-1:0]     pc,
    input  logic [XLEN-1:0]     ra,
    input  logic [XLEN-1:0]     rb,
    input  logic [IMM_W-1:0]    imm,
    input  logic [JMP_W-1:0]    jfield,
    input  logic [XLEN-1:0]     abs_addr,
    output logic                mem_rd_en,
    output logic [XLEN-1:0]     mem_rd_addr,
    input  logic                mem_rd_valid,
    input  logic [XLEN-1:0]     mem_rd_data,
    output logic [XLEN-1:0]     ea,
    output logic                ea_valid,
    output logic                busy,
    output logic                illegal
);

    ea_calc_t        calc;
    logic            accept;
    logic            fsm_busy;
    logic            fsm_done;
    logic [XLEN-1:0] fsm_word;

    ea_mode_calc u_calc (
        .mode     (mode),
        .pc       (pc),
        .ra       (ra),
        .rb       (rb),
        .imm      (imm),
        .jfield   (jfield),
        .abs_addr (abs_addr),
        .res      (calc)
    );

    assign accept = req && !fsm_busy;

    ea_ind_fsm u_ind (
        .clk      (clk),
        .rst      (rst),
        .start    (accept && calc.needs_mem),
        .rd_valid (mem_rd_valid),
        .rd_data  (mem_rd_data),
        .busy     (fsm_busy),
        .done     (fsm_done),
        .word     (fsm_word)
    );

    always_comb begin
        ea       = '0;
        ea_valid = 1'b0;
        if (fsm_done) begin
            ea       = fsm_word;
            ea_valid = 1'b1;
        end else if (accept && calc.arith_ok) begin
            ea       = calc.addr;
            ea_valid = 1'b1;
        end
    end

    assign mem_rd_en   = accept && calc.needs_mem;
    assign mem_rd_addr = calc.addr;
    assign busy        = fsm_busy;
    assign illegal     = accept && calc.bad_mode;

    // R10: an undefined mode never yields an address
    assert_illegal_zero_R10: assert property (@(posedge clk) disable iff (rst)
        illegal |-> (ea == '0 && !ea_valid && !mem_rd_en));

    // R9: no read is issued while a fetch is outstanding
    assert_no_read_when_busy_R9: assert property (@(posedge clk) disable iff (rst)
        busy |-> !mem_rd_en);

    // R9: while waiting, nothing is reported
    assert_quiet_while_waiting_R9: assert property (@(posedge clk) disable iff (rst)
        (busy && !fsm_done) |-> (!ea_valid && !illegal));

    // R6: jump targets are word aligned and keep the upper PC bits
    assert_jump_shape_R6: assert property (@(posedge clk) disable iff (rst)
        (ea_valid && !busy && mode == MODE_JUMP) |->
            (ea[WORD_SHIFT-1:0] == '0 &&
             ea[XLEN-1 -: JMP_HI_W] == next_pc(pc) >> (XLEN-JMP_HI_W)));

    // R7: ea is zero whenever no result is flagged
    assert_idle_zero_R7: assert property (@(posedge clk) disable iff (rst)
        !ea_valid |-> ea == '0);

    // R8: a read is followed by the busy window
    assert_read_then_busy_R8: assert property (@(posedge clk) disable iff (rst)
        mem_rd_en |=> (busy && !ea_valid));

endmodule

// File: tb/tb_eff_addr_gen.sv
`timescale 1ns/1ps
module tb_eff_addr_gen;

    logic        clk = 1'b0;
    logic        rst;
    logic        req;
    logic [2:0]  mode;
    logic [31:0] pc, ra, rb, abs_addr, mem_rd_data;
    logic [15:0] imm;
    logic [25:0] jfield;
    logic        mem_rd_valid;
    logic        mem_rd_en, ea_valid, busy, illegal;
    logic [31:0] mem_rd_addr, ea;

    int nvec = 0;
    int nerr = 0;

    always #2.5 clk = ~clk;

    eff_addr_gen dut (
        .clk(clk), .rst(rst), .req(req), .mode(mode), .pc(pc), .ra(ra), .rb(rb),
        .imm(imm), .jfield(jfield), .abs_addr(abs_addr),
        .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr),
        .mem_rd_valid(mem_rd_valid), .mem_rd_data(mem_rd_data),
        .ea(ea), .ea_valid(ea_valid), .busy(busy), .illegal(illegal)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nvec++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [31:0] mix(input int i, input int k);
        logic [31:0] v;
        case (i)
            0: v = 32'h0000_0000;
            1: v = 32'hFFFF_FFFF;
            2: v = 32'h7FFF_FFFC;
            3: v = 32'hFFFF_FFFC;
            4: v = 32'h8000_0000;
            default: v = (i * 32'h9E37_79B9) ^ (k * 32'h85EB_CA6B) ^ (32'(i) << (k % 13));
        endcase
        return v;
    endfunction

    // arithmetic request; inputs driven after negedge, outputs checked 1 ns later
    task automatic arith_vec(input logic [2:0] m, input int i);
        logic [31:0] exp;
        @(negedge clk);
        req = 1'b1; mode = m;
        pc = mix(i, 1) & 32'hFFFF_FFFC; ra = mix(i, 2); rb = mix(i + 3, 3);
        imm = (i == 5) ? 16'h8000 : (i == 6) ? 16'h7FFF : mix(i, 4)[15:0];
        jfield = mix(i, 5)[25:0]; abs_addr = mix(i, 6);
        case (m)
            3'd0: exp = abs_addr;
            3'd1: exp = ra;
            3'd2: exp = ra + rb;
            3'd3: exp = ra + {{16{imm[15]}}, imm};
            3'd4: exp = pc + 32'd4 + {{14{imm[15]}}, imm, 2'b00};
            default: begin
                exp = pc + 32'd4;
                exp = {exp[31:28], jfield, 2'b00};
            end
        endcase
        #1;
        case (m)
            3'd0: chk("R1 ea", ea, exp);
            3'd1: chk("R2 ea", ea, exp);
            3'd2: chk("R3 ea", ea, exp);
            3'd3: chk("R4 ea", ea, exp);
            3'd4: chk("R5 ea", ea, exp);
            default: chk("R6 ea", ea, exp);
        endcase
        chk("R7 flags", {28'd0, ea_valid, busy, mem_rd_en, illegal}, 32'h8);
    endtask

    task automatic indirect(input logic [31:0] ptr, input logic [31:0] word,
                            input int lat, input bit hold);
        @(negedge clk);
        req = 1'b1; mode = 3'd6; ra = ptr; mem_rd_valid = 1'b0;
        #1;
        chk("R8 read issue", {31'd0, mem_rd_en}, 32'd1);
        chk("R8 read addr", mem_rd_addr, ptr);
        chk("R8 no early valid", {30'd0, ea_valid, busy}, 32'd0);
        for (int c = 0; c <= lat; c++) begin
            @(negedge clk);
            req = hold; mode = (c % 2 == 0) ? 3'd1 : 3'd7; ra = ~ptr;
            if (c == lat) begin
                mem_rd_valid = 1'b1; mem_rd_data = word;
            end
            #1;
            chk("R8 busy wait", {31'd0, busy}, 32'd1);
            chk("R9 ignored req", {29'd0, ea_valid, mem_rd_en, illegal}, 32'd0);
        end
        @(negedge clk);
        mem_rd_valid = 1'b0; mem_rd_data = ~word; mode = 3'd0; abs_addr = ~word;
        #1;
        chk("R8 result", ea, word);
        chk("R8 result flags", {29'd0, ea_valid, busy, mem_rd_en}, 32'h6);
        chk("R9 no illegal in result", {31'd0, illegal}, 32'd0);
        @(negedge clk);
        req = 1'b0;
        #1;
        chk("R8 busy drops", {30'd0, busy, ea_valid}, 32'd0);
    endtask

    initial begin
        rst = 1'b1; req = 1'b0; mode = 3'd0; pc = '0; ra = '0; rb = '0;
        imm = '0; jfield = '0; abs_addr = '0; mem_rd_valid = 1'b0; mem_rd_data = '0;
        repeat (3) @(negedge clk);
        #1;
        chk("R11 reset state", {29'd0, busy, ea_valid, mem_rd_en}, 32'd0);
        @(negedge clk);
        rst = 1'b0;
        #1;
        chk("R11 after reset", {29'd0, busy, ea_valid, mem_rd_en}, 32'd0);

        for (int m = 0; m < 6; m++)
            for (int i = 0; i < 300; i++)
                arith_vec(3'(m), i);

        // R7: valid only in the request cycle
        @(negedge clk);
        req = 1'b0;
        #1;
        chk("R7 no request", {31'd0, ea_valid}, 32'd0);
        chk("R7 zero ea", ea, 32'd0);

        // R10: undefined mode
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            req = 1'b1; mode = 3'd7; ra = mix(i, 7); abs_addr = mix(i, 8);
            #1;
            chk("R10 ea zero", ea, 32'd0);
            chk("R10 flags", {28'd0, illegal, ea_valid, busy, mem_rd_en}, 32'h8);
        end

        // R9: stray read data while idle
        @(negedge clk);
        req = 1'b0; mem_rd_valid = 1'b1; mem_rd_data = 32'hDEAD_BEEF;
        @(negedge clk);
        mem_rd_valid = 1'b0;
        #1;
        chk("R9 stray data", {30'd0, ea_valid, busy}, 32'd0);

        for (int l = 0; l < 5; l++) begin
            indirect(mix(l + 10, 9), mix(l + 10, 10), l, 1'b0);
            indirect(mix(l + 20, 9), mix(l + 20, 10), l, 1'b1);
        end

        // R11: reset while waiting for read data
        @(negedge clk);
        req = 1'b1; mode = 3'd6; ra = 32'h1000;
        @(negedge clk);
        req = 1'b0; rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        #1;
        chk("R11 reset aborts fetch", {30'd0, busy, ea_valid}, 32'd0);
        @(negedge clk);
        req = 1'b1; mode = 3'd1; ra = 32'h1234_5678;
        #1;
        chk("R11 ready after abort", ea, 32'h1234_5678);
        @(negedge clk);
        req = 1'b0;

        $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
        $finish;
    end

    initial begin
        #1000000;
        nerr++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
        $finish;
    end

endmodule